// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block is a clocked front end for an asynchronous static RAM of 128K bytes. A client offers one request at a time on a valid/ready interface. The request carries a write flag, a 17-bit word address and 8 bits of write data. The controller turns each accepted request into a timed pin sequence for the memory. That sequence drives the address, an active-low select, an active-high select, an active-low output enable and an active-low write strobe. The byte-wide data bus is split into an output value, an output-enable and an input value, so a pad at chip level can make it tri-state.

Every timing minimum of the memory is given as a picosecond parameter. Each one becomes a whole number of clock cycles, rounded up, with at least one cycle per phase. Changing the clock period or the speed grade therefore only means changing parameters.

A read keeps the memory selected with output enable low for the whole access phase. It samples the data bus on the last cycle of that phase. It returns the byte with a one-cycle valid pulse. Then it holds the memory deselected until the memory has let go of the bus. A write runs three phases, all controlled by the write strobe: a setup cycle, a strobe-low pulse and a hold phase. The controller drives the data bus only inside the strobe-low pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: A read holds `mem_cs1_n`=0, `mem_cs2`=1, `mem_we_n`=1 and `mem_oe_n`=0, with `mem_addr` equal to the request address and unchanged, for 18 consecutive cycles at the default parameters (ceil(70 ns / 4 ns)).
- R3: The byte on `mem_dq_i` in the last cycle of the read access phase appears on `rsp_rdata`. It is marked by `rsp_valid` high for exactly one cycle, the 19th cycle after the accepting edge.
- R4: A write shows one setup cycle (selected, `mem_we_n`=1). Then `mem_we_n` is low for 14 cycles (the largest of strobe width, address-to-strobe-end less setup, and data setup plus one). Then come 3 hold cycles, still selected with `mem_we_n`=1, so the whole write lasts at least the 70 ns cycle time.
- R5: `mem_dq_oe` is 1 only while `mem_we_n`=0 and `mem_oe_n`=1. It rises one cycle after `mem_we_n` falls and falls in the cycle `mem_we_n` rises. While it is 1, `mem_dq_o` equals the request write data.
- R6: After a read's access phase, the memory is deselected with `mem_oe_n`=1 for 8 cycles (ceil(30 ns / 4 ns)) before `req_ready` returns.
- R7: `req_ready` goes low on the edge after acceptance. It stays low for 18 cycles for a write and 26 cycles for a read.
- R8: `req_valid` while `req_ready` is 0 is ignored. No extra memory cycle starts, and the stored data is unchanged.
- R9: The controller never drives the data bus while the memory may still be driving it, including the 30 ns release after a read.
- R10: Every write meets, in nanoseconds, strobe width at least 35, address valid at least 60 before the strobe rises, data stable at least 35 before it, and an address hold of at least 5 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low select |
| mem_cs2 | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_i | input | 8 | Data from the memory pins |

## Verification
The bench uses a memory model that returns the inverted byte whenever the address, select or output-enable time has not yet passed. A controller that samples too early therefore returns wrong read data instead of passing by luck. The model measures every write strobe, address window and data-stable window in nanoseconds. It also flags any cycle in which the controller drives the bus inside the 30 ns release after a read. A shortened recovery phase, or a driver enabled too early, would show up there. A request pulsed during a busy write must leave both the pin sequence and the stored byte untouched. Otherwise a design that latched it would overwrite data or start a second strobe.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   // Sequencer phases
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_WSETUP = 3'd1,
      PH_WPULSE = 3'd2,
      PH_WHOLD  = 3'd3,
      PH_RACC   = 3'd4,
      PH_RREL   = 3'd5
   } phase_e;

   // Memory control pins, all as seen on the wire
   typedef struct packed {
      logic cs1_n;
      logic cs2;
      logic oe_n;
      logic we_n;
   } pins_t;

   // Nanosecond-scale minimum to clock cycles, rounded up, never below one
   function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Pin levels belonging to each phase
   function automatic pins_t pins_of(input phase_e p);
      pins_t r;
      case (p)
         PH_WSETUP: r = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1};
         PH_WPULSE: r = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b0};
         PH_WHOLD:  r = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b1, we_n: 1'b1};
         PH_RACC:   r = '{cs1_n: 1'b0, cs2: 1'b1, oe_n: 1'b0, we_n: 1'b1};
         default:   r = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("sram_phase_timer: CNT_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int DATA_W  = 8,
   parameter int CNT_W   = 5,
   parameter int SETUP_C = 1,
   parameter int PULSE_C = 14,
   parameter int HOLD_C  = 3,
   parameter int RD_C    = 18,
   parameter int TA_C    = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  logic              tmr_done,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output pins_t             pins,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              capture,
   output logic              drive
);

   localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_C - 1);
   localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(PULSE_C - 1);
   localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_C - 1);
   localparam logic [CNT_W-1:0] L_RD    = CNT_W'(RD_C - 1);
   localparam logic [CNT_W-1:0] L_TA    = CNT_W'(TA_C - 1);

   generate
      if (SETUP_C < 1 || PULSE_C < 2 || HOLD_C < 1 || RD_C < 1 || TA_C < 1) begin : g_bad_phase
         $error("sram_seq_fsm: phase lengths out of range");
      end
   endgenerate

   phase_e state_q, state_d;
   pins_t  pins_q;
   logic   drive_q;
   logic   accept;

   assign req_ready = (state_q == PH_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      capture  = 1'b0;
      case (state_q)
         PH_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_we) begin
                  state_d = PH_WSETUP;
                  tmr_val = L_SETUP;
               end else begin
                  state_d = PH_RACC;
                  tmr_val = L_RD;
               end
            end
         end
         PH_WSETUP: begin
            if (tmr_done) begin
               state_d  = PH_WPULSE;
               tmr_load = 1'b1;
               tmr_val  = L_PULSE;
            end
         end
         PH_WPULSE: begin
            if (tmr_done) begin
               state_d  = PH_WHOLD;
               tmr_load = 1'b1;
               tmr_val  = L_HOLD;
            end
         end
         PH_WHOLD: begin
            if (tmr_done) state_d = PH_IDLE;
         end
         PH_RACC: begin
            if (tmr_done) begin
               state_d  = PH_RREL;
               tmr_load = 1'b1;
               tmr_val  = L_TA;
               capture  = 1'b1;
            end
         end
         PH_RREL: begin
            if (tmr_done) state_d = PH_IDLE;
         end
         default: state_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PH_IDLE;
         pins_q  <= pins_of(PH_IDLE);
         drive_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         pins_q  <= pins_of(state_d);
         // driver comes on from the second strobe-low cycle, off as the strobe rises
         drive_q <= (state_d == PH_WPULSE) && (state_q == PH_WPULSE);
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   assign pins  = pins_q;
   assign drive = drive_q;

   // R1: idle pin levels
   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (pins_q.cs1_n && !pins_q.cs2 && pins_q.oe_n && pins_q.we_n && !drive_q));

   // R4: strobe only while selected
   assert_we_selected_R4: assert property (@(posedge clk) disable iff (rst)
      !pins_q.we_n |-> (!pins_q.cs1_n && pins_q.cs2));

   // R5: never strobe with output enable active
   assert_we_oe_excl_R5: assert property (@(posedge clk) disable iff (rst)
      !pins_q.we_n |-> pins_q.oe_n);

   // R2: address frozen while selected
   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!pins_q.cs1_n && $past(!pins_q.cs1_n)) |-> $stable(addr_q));

   // R7: busy after acceptance
   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
   parameter int DATA_W   = 8,
   parameter bit PARK_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              capture,
   input  logic              drive,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("sram_dq_path: DATA_W must be at least 1");
      end
      if (PARK_LOW) begin : g_park
         // outgoing value held at zero while the pad is off
         always_comb dq_o = drive ? wdata : '0;
      end else begin : g_follow
         always_comb dq_o = wdata;
      end
   endgenerate

   assign dq_oe = drive;

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= capture;
         if (capture) rdata <= dq_i;
      end
   end

   // R3: read data marker lasts a single cycle
   assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int CLK_PS   = 4000,
   parameter int T_RC_PS  = 70000,
   parameter int T_AA_PS  = 70000,
   parameter int T_ACS_PS = 70000,
   parameter int T_OE_PS  = 30000,
   parameter int T_HZ_PS  = 30000,
   parameter int T_WC_PS  = 70000,
   parameter int T_AS_PS  = 0,
   parameter int T_WP_PS  = 35000,
   parameter int T_AW_PS  = 60000,
   parameter int T_DW_PS  = 35000,
   parameter int T_WR_PS  = 5000,
   parameter bit PARK_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   // per-phase cycle counts
   localparam int AS_C  = ps_to_cyc(T_AS_PS, CLK_PS);
   localparam int WP_C  = ps_to_cyc(T_WP_PS, CLK_PS);
   localparam int AW_C  = ps_to_cyc(T_AW_PS, CLK_PS);
   localparam int DW_C  = ps_to_cyc(T_DW_PS, CLK_PS);
   localparam int WR_C  = ps_to_cyc(T_WR_PS, CLK_PS);
   localparam int WC_C  = ps_to_cyc(T_WC_PS, CLK_PS);
   localparam int AA_C  = ps_to_cyc(T_AA_PS, CLK_PS);
   localparam int ACS_C = ps_to_cyc(T_ACS_PS, CLK_PS);
   localparam int OE_C  = ps_to_cyc(T_OE_PS, CLK_PS);
   localparam int HZ_C  = ps_to_cyc(T_HZ_PS, CLK_PS);
   localparam int RC_C  = ps_to_cyc(T_RC_PS, CLK_PS);

   localparam int SETUP_C = AS_C;
   // data goes on the bus one cycle into the strobe, so it needs one extra
   localparam int PULSE_C = max2(WP_C, max2(AW_C - SETUP_C, DW_C + 1));
   localparam int HOLD_C  = max2(WR_C, WC_C - SETUP_C - PULSE_C);
   localparam int RD_C    = max2(AA_C, max2(ACS_C, OE_C));
   localparam int TA_C    = max2(HZ_C, RC_C - RD_C);
   localparam int MAX_C   = max2(max2(SETUP_C, PULSE_C), max2(max2(HOLD_C, RD_C), TA_C));
   localparam int CNT_W   = $clog2(MAX_C + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
         $error("sram_async_ctrl: bus widths must be positive");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("sram_async_ctrl: CLK_PS must be positive");
      end
   endgenerate

   logic             tmr_load, tmr_done, capture, drive;
   logic [CNT_W-1:0] tmr_val;
   logic [DATA_W-1:0] wdata_q;
   pins_t            pins;

   sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_seq_fsm #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W),
      .SETUP_C(SETUP_C), .PULSE_C(PULSE_C), .HOLD_C(HOLD_C),
      .RD_C   (RD_C), .TA_C (TA_C)
   ) fsm_i (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_ready (req_ready),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .pins      (pins),
      .addr_q    (mem_addr),
      .wdata_q   (wdata_q),
      .capture   (capture),
      .drive     (drive)
   );

   sram_dq_path #(.DATA_W(DATA_W), .PARK_LOW(PARK_LOW)) dq_i (
      .clk     (clk),
      .rst     (rst),
      .capture (capture),
      .drive   (drive),
      .wdata   (wdata_q),
      .dq_i    (mem_dq_i),
      .dq_o    (mem_dq_o),
      .dq_oe   (mem_dq_oe),
      .rdata   (rsp_rdata),
      .rvalid  (rsp_valid)
   );

   assign mem_cs1_n = pins.cs1_n;
   assign mem_cs2   = pins.cs2;
   assign mem_oe_n  = pins.oe_n;
   assign mem_we_n  = pins.we_n;

   // R5: pad driver only inside an established strobe with output enable off
   assert_drive_gate_R5: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> (!mem_we_n && mem_oe_n && $past(!mem_we_n)));

   // R5: driver released as the strobe rises
   assert_drive_release_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_we_n) |-> !mem_dq_oe);

   // R9: no read data return while the pad driver is on
   assert_no_rsp_in_write_R9: assert property (@(posedge clk) disable iff (rst)
      mem_dq_oe |-> !rsp_valid);

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

   localparam real CLK_NS = 4.0;
   // expected phase lengths at 4 ns clock, 70 ns grade (see requirements)
   localparam int E_SETUP = 1;
   localparam int E_PULSE = 14;
   localparam int E_HOLD  = 3;
   localparam int E_RD    = 18;
   localparam int E_TA    = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_o;
   logic [7:0]  mem_dq_i = '0;

   int n_chk = 0;
   int n_bad = 0;
   int n_commit = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sram_async_ctrl dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   logic [7:0] mem [logic [16:0]];
   real  t_addr, t_sel, t_oef, t_wef, t_wer, t_d, t_rel, now;
   logic [16:0] p_addr;
   logic p_sel, p_we_n, p_oe_n, p_drv, d_ok;
   logic [7:0] d_val;

   function automatic logic [7:0] peek(input logic [16:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   always @(negedge clk) begin
      logic sel, drv;
      now = $realtime;
      sel = !mem_cs1_n && mem_cs2;
      if (rst) begin
         t_addr = now; t_sel = -1000.0; t_oef = -1000.0; t_wef = -1000.0;
         t_wer = -1000.0; t_d = -1000.0; t_rel = -1000.0;
         p_addr = mem_addr; p_sel = 1'b0; p_we_n = 1'b1; p_oe_n = 1'b1;
         p_drv = 1'b0; d_ok = 1'b0; d_val = '0;
         mem_dq_i = 8'h00;
      end else begin
         if (mem_addr != p_addr) begin
            if (now - t_wer < 5.0) check(1'b0, "R10 address hold", int'(now - t_wer), 5);
            t_addr = now;
         end
         if (sel && !p_sel) t_sel = now;
         if (!mem_oe_n && p_oe_n) t_oef = now;
         if (!mem_we_n && p_we_n) begin t_wef = now; d_ok = 1'b0; end
         if (!mem_we_n && mem_dq_oe && (!d_ok || mem_dq_o != d_val)) begin
            t_d = now; d_val = mem_dq_o; d_ok = 1'b1;
         end
         if (mem_we_n && !p_we_n) begin
            check(now - t_wef >= 35.0, "R10 strobe width", int'(now - t_wef), 35);
            check(now - t_addr >= 60.0, "R10 address to strobe end", int'(now - t_addr), 60);
            check(d_ok && (now - t_d >= 35.0), "R10 data setup", int'(now - t_d), 35);
            check(p_sel, "R10 selected at strobe end", int'(p_sel), 1);
            if (d_ok) mem[p_addr] = d_val;
            t_wer = now;
            n_commit++;
         end
         drv = sel && !mem_oe_n && mem_we_n;
         if (p_drv && !drv) t_rel = now;
         if (mem_dq_oe && (drv || (now - t_rel < 30.0)))
            check(1'b0, "R9 bus contention", int'(now - t_rel), 30);
         if (drv) begin
            if ((now - t_addr + CLK_NS >= 70.0) && (now - t_sel + CLK_NS >= 70.0) &&
                (now - t_oef + CLK_NS >= 30.0))
               mem_dq_i = peek(mem_addr);
            else
               mem_dq_i = ~peek(mem_addr);
         end else begin
            mem_dq_i = 8'h00;
         end
         p_addr = mem_addr; p_sel = sel; p_we_n = mem_we_n;
         p_oe_n = mem_oe_n; p_drv = drv;
      end
   end

   // ---------------- scenario tasks ----------------
   task automatic issue(input bit we, input logic [16:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      check({mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n} == 4'b1011, "R1 idle pins",
            int'({mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}), 4'b1011);
      check(!mem_dq_oe && !rsp_valid, "R1 no drive, no response",
            int'({mem_dq_oe, rsp_valid}), 0);
   endtask

   task automatic t_write(input logic [16:0] a, input logic [7:0] d,
                          input bit poke, input logic [16:0] pa, input logic [7:0] pd);
      int setup = 0, wlow = 0, hold = 0, first_we = 0, first_oe = 0, n_oe = 0;
      int bad_gate = 0, bad_data = 0, busy = 0;
      issue(1'b1, a, d);
      for (int k = 1; k <= 60; k++) begin
         if (req_ready) begin busy = k - 1; break; end
         if (poke && k == 5) begin
            req_valid = 1'b1; req_we = 1'b1; req_addr = pa; req_wdata = pd;
         end
         if (poke && k == 6) req_valid = 1'b0;
         if (!mem_cs1_n && mem_cs2) begin
            if (mem_we_n && first_we == 0) setup++;
            if (!mem_we_n) begin wlow++; if (first_we == 0) first_we = k; end
            if (mem_we_n && first_we != 0) hold++;
         end
         if (mem_dq_oe) begin
            n_oe++;
            if (first_oe == 0) first_oe = k;
            if (mem_we_n || !mem_oe_n) bad_gate++;
            if (mem_dq_o != d) bad_data++;
         end
         @(negedge clk);
      end
      check(setup == E_SETUP, "R4 setup cycles", setup, E_SETUP);
      check(wlow == E_PULSE, "R4 strobe low cycles", wlow, E_PULSE);
      check(hold == E_HOLD, "R4 hold cycles", hold, E_HOLD);
      check(first_oe == first_we + 1, "R5 driver start", first_oe, first_we + 1);
      check(n_oe == E_PULSE - 1, "R5 driver cycles", n_oe, E_PULSE - 1);
      check(bad_gate == 0 && bad_data == 0, "R5 driver gating and data", bad_gate + bad_data, 0);
      check(busy == E_SETUP + E_PULSE + E_HOLD, "R7 write busy", busy, E_SETUP + E_PULSE + E_HOLD);
      if (poke) begin
         int extra = 0;
         for (int k = 0; k < 6; k++) begin
            if (!mem_we_n || !mem_cs1_n || !req_ready) extra++;
            @(negedge clk);
         end
         check(extra == 0, "R8 no cycle from ignored request", extra, 0);
      end
   endtask

   task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
      int oe_low = 0, rsp_k = 0, n_rsp = 0, rel = 0, busy = 0, bad_addr = 0;
      logic [7:0] got = '0;
      issue(1'b0, a, 8'h00);
      for (int k = 1; k <= 60; k++) begin
         if (req_ready) begin busy = k - 1; break; end
         if (!mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n) begin
            oe_low++;
            if (mem_addr != a) bad_addr++;
         end
         if (oe_low != 0 && mem_cs1_n && !mem_cs2 && mem_oe_n) rel++;
         if (rsp_valid) begin n_rsp++; rsp_k = k; got = rsp_rdata; end
         @(negedge clk);
      end
      check(oe_low == E_RD && bad_addr == 0, "R2 read access cycles", oe_low, E_RD);
      check(n_rsp == 1 && rsp_k == E_RD + 1, "R3 response cycle", rsp_k, E_RD + 1);
      check(got == exp, "R3 read data", int'(got), int'(exp));
      check(rel == E_TA, "R6 release cycles", rel, E_TA);
      check(busy == E_RD + E_TA, "R7 read busy", busy, E_RD + E_TA);
   endtask

   // ---------------- sequence ----------------
   initial begin
      t_reset();
      t_write(17'h00000, 8'h5A, 1'b0, '0, '0);
      t_write(17'h1FFFF, 8'hA5, 1'b0, '0, '0);
      t_write(17'h0AAAA, 8'hFF, 1'b0, '0, '0);
      t_write(17'h15555, 8'h00, 1'b0, '0, '0);
      t_read(17'h00000, 8'h5A);
      t_read(17'h1FFFF, 8'hA5);
      t_read(17'h0AAAA, 8'hFF);
      t_read(17'h15555, 8'h00);
      t_read(17'h01234, 8'h00);
      t_write(17'h00000, 8'hC3, 1'b0, '0, '0);
      t_read(17'h00000, 8'hC3);
      // R8: request pulsed while busy must be dropped
      t_write(17'h00100, 8'h11, 1'b1, 17'h1FFFF, 8'h3C);
      t_read(17'h1FFFF, 8'hA5);
      // read followed at once by a write: turnaround (R9)
      t_read(17'h00100, 8'h11);
      t_write(17'h00200, 8'h77, 1'b0, '0, '0);
      t_read(17'h00200, 8'h77);
      check(n_commit == 7, "R4 strobes seen by memory", n_commit, 7);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule